// File: doc/BRIEF.md
# GPIO Bank Interrupt Sense Controller

A bank of general-purpose pins with a word-addressed register port. Software programs an output value and a per-pin direction, reads back a data word that mixes driven values and sampled pad levels, and arms each input pin to flag one of five conditions: rising edge, falling edge, either edge, high level or low level. Each flagged condition is held in a sticky status bit, and a single interrupt line reports any status bit whose enable is set.

The sense condition of a pin is not a single mode field. It is the combination of three independent per-bit configuration words (sense-select A, B and C), so one register write can change the mode of many pins. Pads are asynchronous. They pass through a synchroniser, and edge detection compares the synchronised level with the level one cycle older. Status bits clear when software writes a one to them.

Top module: `gpio_sense_bank`

## Requirements
- R1: After reset every register reads zero, pad_o and pad_oe_o are zero and irq_o is low.
- R2: Byte offset 0x00 holds the output value driven on pad_o. Offset 0x04 holds the direction word on pad_oe_o, where bit n = 1 makes pin n an output. Both take the written value on the clock edge of the write.
- R3: A read of offset 0x00 returns, for each output pin, the driven value and, for each input pin, the pad level after a two-flop synchroniser. A pad change becomes visible in the read two clock edges after it is applied.
- R4: Sense-select B = 0, A = 1 and C = 0 flags a rising edge only. Offset 0x0C is A, 0x10 is B and 0x14 is C. The status bit is readable, and irq_o is high, three edges after the pad rises.
- R5: B = 0, A = 0 and C = 0 flags a falling edge only.
- R6: B = 0 with C = 1 flags both edges, whatever the value of A.
- R7: B = 1 selects level sensing: A = 1 flags a high level and A = 0 a low level. C is ignored.
- R8: Status (offset 0x18) bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: For a level-sensed pin, a clear wins in the cycle of the write. If the level still holds, the bit sets again one cycle later.
- R10: For an edge-sensed pin, an edge detected in the same cycle as a clear of that bit leaves the bit set.
- R11: A pin whose direction bit is 1 never sets its status bit.
- R12: Enable (offset 0x08) does not affect status latching. irq_o is high exactly when some bit is set in both status and enable.
- R13: Offsets 0x1C and above, and addresses with either low bit set, read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | NUM_PINS | Write data |
| rdata_o | output | NUM_PINS | Read data for addr_i, combinational |
| pad_i | input | NUM_PINS | Asynchronous pad levels |
| pad_o | output | NUM_PINS | Driven output value |
| pad_oe_o | output | NUM_PINS | Output enable per pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that wr_en_i, addr_i and wdata_i are known and stable around each clock edge, and that a status write is decoded only at the aligned offset 0x18. They place no limit on how often pad_i toggles. The stimulus changes every input only on the falling clock edge. Addresses are drawn only from aligned word offsets. Pad toggles and direction writes are thinned so that levels persist long enough for the level modes and the clear-and-reset behaviour to occur often.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;
  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned IDX_LSB   = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_EN   = 3'd2,
    REG_SA   = 3'd3,
    REG_SB   = 3'd4,
    REG_SC   = 3'd5,
    REG_STAT = 3'd6
  } reg_idx_e;

  typedef struct packed {
    logic sel_a;
    logic sel_b;
    logic sel_c;
  } sense_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= d_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
    end
  end

  assign q_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/gpio_sense_cell.sv
module gpio_sense_cell
  import gpio_sense_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_i,
  input  logic       is_out_i,
  input  sense_cfg_t cfg_i,
  input  logic       clr_i,
  output logic       status_o
);
  logic prev_q;
  logic st_q;
  logic hit;

  always_comb begin
    if (is_out_i)          hit = 1'b0;
    else if (cfg_i.sel_b)  hit = cfg_i.sel_a ? smp_i : ~smp_i;
    else if (cfg_i.sel_c)  hit = smp_i ^ prev_q;
    else if (cfg_i.sel_a)  hit = smp_i & ~prev_q;
    else                   hit = ~smp_i & prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= smp_i;
  end

  // level: clear wins (condition re-asserts next cycle); edge: set wins so no edge is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            st_q <= 1'b0;
    else if (cfg_i.sel_b)   st_q <= clr_i ? 1'b0 : (st_q | hit);
    else if (hit)           st_q <= 1'b1;
    else if (clr_i)         st_q <= 1'b0;
  end

  assign status_o = st_q;
endmodule

// File: rtl/gpio_sense_bank.sv
module gpio_sense_bank
  import gpio_sense_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int unsigned HI_LSB = IDX_LSB + REG_IDX_W;

  logic [NUM_PINS-1:0] data_q, dir_q, en_q, sa_q, sb_q, sc_q;
  logic [NUM_PINS-1:0] smp, status_q, clr_vec;
  logic                upper_zero, in_map, wr_hit;
  reg_idx_e            idx;

  if (ADDR_W > HI_LSB) begin : g_hi
    assign upper_zero = (addr_i[ADDR_W-1:HI_LSB] == '0);
  end else begin : g_nohi
    assign upper_zero = 1'b1;
  end

  assign idx    = reg_idx_e'(addr_i[IDX_LSB +: REG_IDX_W]);
  assign in_map = upper_zero && (addr_i[IDX_LSB-1:0] == '0);
  assign wr_hit = wr_en_i && in_map;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      sa_q   <= '0;
      sb_q   <= '0;
      sc_q   <= '0;
    end else if (wr_hit) begin
      case (idx)
        REG_DATA: data_q <= wdata_i;
        REG_DIR:  dir_q  <= wdata_i;
        REG_EN:   en_q   <= wdata_i;
        REG_SA:   sa_q   <= wdata_i;
        REG_SB:   sb_q   <= wdata_i;
        REG_SC:   sc_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr_hit && idx == REG_STAT) ? wdata_i : '0;

  gpio_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (smp)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    sense_cfg_t cfg;
    assign cfg = '{sel_a: sa_q[g], sel_b: sb_q[g], sel_c: sc_q[g]};

    gpio_sense_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .smp_i    (smp[g]),
      .is_out_i (dir_q[g]),
      .cfg_i    (cfg),
      .clr_i    (clr_vec[g]),
      .status_o (status_q[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (in_map) begin
      case (idx)
        REG_DATA: rdata_o = (dir_q & data_q) | (~dir_q & smp);
        REG_DIR:  rdata_o = dir_q;
        REG_EN:   rdata_o = en_q;
        REG_SA:   rdata_o = sa_q;
        REG_SB:   rdata_o = sb_q;
        REG_SC:   rdata_o = sc_q;
        REG_STAT: rdata_o = status_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign pad_o    = data_q;
  assign pad_oe_o = dir_q;
  assign irq_o    = |(status_q & en_q);
endmodule

// File: rtl/gpio_sense_bank_chk.sv
module gpio_sense_bank_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] sb_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] status_q
);
  logic                stat_wr, dir_wr;
  logic [NUM_PINS-1:0] clr_v;

  assign stat_wr = wr_en_i && (addr_i == ADDR_W'(24));
  assign dir_wr  = wr_en_i && (addr_i == ADDR_W'(4));
  assign clr_v   = stat_wr ? wdata_i : '0;

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr |=> (pad_oe_o == $past(wdata_i)));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~status_q & $past(status_q) & ~$past(clr_v)) == '0));

  p_level_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr |=> ((status_q & $past(wdata_i & sb_q)) == '0));

  p_out_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & $past(dir_q)) == '0));

  p_irq_en_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0));

  p_irq_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q != '0));
endmodule

bind gpio_sense_bank gpio_sense_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pad_oe_o (pad_oe_o),
  .irq_o    (irq_o),
  .en_q     (en_q),
  .sb_q     (sb_q),
  .dir_q    (dir_q),
  .status_q (status_q)
);

// File: tb/gpio_sense_bank_test.sv
module gpio_sense_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_EN = 5'h08,
                         A_SA = 5'h0C, A_SB = 5'h10, A_SC = 5'h14,
                         A_STAT = 5'h18, A_NONE = 5'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [4:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic [N-1:0]  pad = '0;
  logic [N-1:0]  pad_o, pad_oe;
  logic          irq;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_sense_bank uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pad_i    (pad),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe),
    .irq_o    (irq)
  );

  // reference model state, derived from the requirements
  logic [N-1:0] m_data, m_dir, m_en, m_sa, m_sb, m_sc, m_stat, m_s1, m_s2, m_prev;

  function automatic logic [N-1:0] exp_hit(input logic [N-1:0] s, p, dir, sa, sb, sc);
    logic [N-1:0] h;
    for (int i = 0; i < N; i++) begin
      if (dir[i])     h[i] = 1'b0;
      else if (sb[i]) h[i] = sa[i] ? s[i] : !s[i];
      else if (sc[i]) h[i] = s[i] != p[i];
      else if (sa[i]) h[i] = s[i] && !p[i];
      else            h[i] = !s[i] && p[i];
    end
    return h;
  endfunction

  function automatic logic [N-1:0] exp_status(input logic [N-1:0] st, hit, clr, sb);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (sb[i]) r[i] = clr[i] ? 1'b0 : (st[i] | hit[i]);
      else       r[i] = hit[i] ? 1'b1 : (clr[i] ? 1'b0 : st[i]);
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_read(input logic [4:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[4:2])
      3'd0: return (m_dir & m_data) | (~m_dir & m_s2);
      3'd1: return m_dir;
      3'd2: return m_en;
      3'd3: return m_sa;
      3'd4: return m_sb;
      3'd5: return m_sc;
      3'd6: return m_stat;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0; m_dir = '0; m_en = '0; m_sa = '0; m_sb = '0; m_sc = '0;
      m_stat = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
    end else begin
      logic [N-1:0] hit, clr;
      hit = exp_hit(m_s2, m_prev, m_dir, m_sa, m_sb, m_sc);
      clr = (wr_en && addr == A_STAT) ? wdata : '0;
      m_stat = exp_status(m_stat, hit, clr, m_sb);
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = pad;
      if (wr_en && addr[1:0] == 2'b00) begin
        case (addr[4:2])
          3'd0: m_data = wdata;
          3'd1: m_dir = wdata;
          3'd2: m_en = wdata;
          3'd3: m_sa = wdata;
          3'd4: m_sb = wdata;
          3'd5: m_sc = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R2 pad_o", pad_o, m_data);
    chk("R2 pad_oe_o", pad_oe, m_dir);
    chk("R12 irq_o", N'(irq), N'(|(m_stat & m_en)));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [N-1:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  function automatic string tag_of(input logic [4:0] a);
    if (a[1:0] != 2'b00) return "R13";
    case (a[4:2])
      3'd0: return "R3";
      3'd1: return "R2";
      3'd2: return "R12";
      3'd3, 3'd4, 3'd5: return "R7";
      3'd6: return "R8";
      default: return "R13";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 pad_o in reset", pad_o, '0);
    chk("R1 irq in reset", N'(irq), '0);
    rst_n = 1'b1;
    tick();
    for (int k = 0; k < 8; k++) begin
      rd(5'(k * 4), v);
      chk("R1 reset register", v, '0);
    end

    // R13: unmapped and misaligned writes change nothing
    wr(A_NONE, '1);
    wr(5'h05, '1);
    rd(A_NONE, v);   chk("R13 unmapped read", v, '0);
    rd(A_DIR, v);    chk("R13 dir untouched", v, '0);
    rd(A_EN, v);     chk("R13 enable untouched", v, '0);

    // R2 / R3
    wr(A_DIR, 32'h20);
    chk("R2 direction out", pad_oe, 32'h20);
    wr(A_DATA, 32'h20);
    chk("R2 data out", pad_o, 32'h20);
    pad[6] = 1'b1;
    tick();
    rd(A_DATA, v); chk("R3 one edge latency", v, 32'h20);
    tick();
    rd(A_DATA, v); chk("R3 synced input read", v, 32'h60);

    // R11: output pin ignores its pad
    wr(A_SC, 32'h20);
    pad[5] = 1'b1;
    ticks(4);
    rd(A_STAT, v); chk("R11 output pin no status", v, '0);
    pad[5] = 1'b0;
    ticks(4);
    rd(A_STAT, v); chk("R11 output pin no status fall", v, '0);

    // R4 rising edge with three-edge latency
    wr(A_SA, 32'h01);
    wr(A_EN, 32'h01);
    pad[0] = 1'b1;
    ticks(2);
    chk("R4 irq not yet", N'(irq), '0);
    tick();
    chk("R4 irq after rise", N'(irq), 1);
    rd(A_STAT, v); chk("R4 status after rise", v, 32'h1);

    // R8 write-one-to-clear
    wr(A_STAT, '0);
    rd(A_STAT, v); chk("R8 zero write keeps", v, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R8 one write clears", v, '0);
    chk("R8 irq drops", N'(irq), '0);
    pad[0] = 1'b0;
    ticks(4);
    rd(A_STAT, v); chk("R4 falling ignored", v, '0);

    // R5 falling edge
    pad[1] = 1'b1;
    ticks(4);
    rd(A_STAT, v); chk("R5 rise ignored", v, '0);
    pad[1] = 1'b0;
    ticks(4);
    rd(A_STAT, v); chk("R5 fall flagged", v, 32'h2);

    // R12 enable gates only the interrupt
    chk("R12 masked irq", N'(irq), '0);
    wr(A_EN, 32'h3);
    chk("R12 unmasked irq", N'(irq), 1);
    wr(A_STAT, 32'h2);
    wr(A_EN, '0);

    // R6 both edges
    wr(A_SC, 32'h24);
    pad[2] = 1'b1;
    ticks(4);
    rd(A_STAT, v); chk("R6 rise flagged", v, 32'h4);
    wr(A_STAT, 32'h4);
    pad[2] = 1'b0;
    ticks(4);
    rd(A_STAT, v); chk("R6 fall flagged", v, 32'h4);
    wr(A_STAT, 32'h4);

    // R7 / R9 levels on bit 3
    wr(A_SA, 32'h09);
    wr(A_SB, 32'h08);
    ticks(2);
    rd(A_STAT, v); chk("R7 high level absent", v, '0);
    pad[3] = 1'b1;
    ticks(3);
    rd(A_STAT, v); chk("R7 high level flagged", v, 32'h8);
    wr(A_STAT, 32'h8);
    rd(A_STAT, v); chk("R9 clear wins in write cycle", v, '0);
    tick();
    rd(A_STAT, v); chk("R9 level re-sets", v, 32'h8);
    pad[3] = 1'b0;
    ticks(3);
    wr(A_STAT, 32'h8);
    tick();
    rd(A_STAT, v); chk("R7 high level gone", v, '0);
    wr(A_SA, 32'h01);
    rd(A_STAT, v); chk("R7 low level not yet", v, '0);
    tick();
    rd(A_STAT, v); chk("R7 low level flagged", v, 32'h8);
    wr(A_SB, '0);
    wr(A_STAT, 32'h8);

    // R10 edge coinciding with clear
    wr(A_SA, 32'h11);
    pad[4] = 1'b1;
    ticks(2);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); chk("R10 edge beats clear", v, 32'h10);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); chk("R10 later clear works", v, '0);

    // constrained random phase against the model
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] d;
      logic [4:0]   a;
      pad = pad ^ ($urandom & $urandom & $urandom);
      a = 5'(($urandom % 8) * 4);
      d = $urandom;
      if (a == A_DIR) d = d & $urandom & $urandom;
      wr_en = ($urandom % 4) == 0;
      addr = a;
      wdata = d;
      #1;
      chk(tag_of(a), rdata, exp_read(a));
      tick();
    end
    wr_en = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule